// File: doc/BRIEF.md
# Battery-Backed Byte-Wide RAM Access Gate

This block holds the control logic of a non-volatile, byte-wide static RAM module. The module has up to 32K x 8 of storage. Its host sees an ordinary asynchronous SRAM interface: active-low chip, write and output enables, a 15-bit address and an 8-bit data path. The bidirectional data path is split into an input, an output and a drive enable, and a pad ring outside the block joins them. Two more inputs come from the module's own circuitry. One is a digitized supply-good level. The other is a manual switch that makes the storage read-only. The block decides in which cycles a read or a write takes place, when the data outputs are driven and when every access is refused. The storage array lives inside the block.

All pins are brought into the system clock domain by a synchronizer of `SYNC_STAGES` flops. Address and write data go through the same number of flops, so they stay aligned with the controls. A state machine runs on the synchronized pins. Its states are:

- `ST_OFF`: the supply is low.
- `ST_IDLE`: no access is in progress.
- `ST_READ`: a read is in progress.
- `ST_WRITE`: an accepted write is in progress.
- `ST_REJECT`: a refused write is in progress.

Its transitions are:

- Any state goes to OFF when the supply drops.
- OFF goes to IDLE once the supply is good and no write is asserted.
- IDLE goes to READ when CE falls while WE is high.
- IDLE or READ goes to WRITE or REJECT when a write starts.
- READ goes to IDLE when CE rises.
- WRITE or REJECT goes to IDLE when CE or WE rises.

A write is committed to the array on the exit from WRITE.

Top module: `nvram_gate`

## Requirements
- R1: With the supply good, CE low, WE high and OE low, `data_oe` is 1 and `data_out` carries the byte stored at the address. In every other case `data_oe` is 0 and `data_out` is 0.
- R2: A write is in progress only while CE and WE are both low. The byte stored is the one on `data_in` at the moment the write ends, at the address present at that moment.
- R3: A write ends at the first rising edge of either CE or WE. A write ended by CE rising while WE stays low is committed.
- R4: If WE falls during an enabled read, `data_oe` returns to 0. The write that follows is committed when WE rises.
- R5: If WE is already low when CE falls, `data_oe` stays 0 for the whole cycle, even with OE low.
- R6: While `supply_ok` is 0, `data_oe` stays 0 and writes change no stored byte.
- R7: While `wp_sw` is 1, writes change no stored byte, and reads work as in R1.
- R8: With `DENSITY_KB` of 2, 8 or 16, address bits from `log2(DENSITY_KB*1024)` upward are ignored. With the default of 2, bits 14..11 are ignored, so address 0x0805 reaches the same byte as 0x0005. With 24, addresses of 24576 and above read as 0 and are not written.
- R9: A write that starts after WE has been high for fewer than `REC_CYC` synchronized cycles is discarded. The default is 4. A write that starts after WE has been high for `REC_CYC` or more cycles is accepted.
- R10: When `ERR_EN` is 1, `err_flag` pulses high for exactly one cycle at the start of each write attempted while `wp_sw` is 1 or `supply_ok` is 0. Accepted writes give no pulse.
- R11: After reset, `data_oe` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address |
| data_in | input | 8 | Data driven by the host |
| data_out | output | 8 | Read data, 0 when not driven |
| data_oe | output | 1 | Pad drive enable for `data_out` |
| supply_ok | input | 1 | Digitized supply-good level |
| wp_sw | input | 1 | Manual write-protect switch, 1 = protected |
| err_flag | output | 1 | One-cycle pulse on a blocked write attempt |

## Verification
The hardest case to reach from the ports is a write that is refused only because the previous write ended too recently. To reach it, the host must raise WE for a single cycle and lower it again while CE stays low. This gives a high time on the synchronized WE that is shorter than the recovery limit. The bench does exactly this with a first write, then reads the address back to show the second byte was dropped. It repeats the sequence with a long high time to show the second write is then accepted. A second case that is hard to reach is a write that ends on CE while WE stays low. The bench holds WE low past the CE rise and only releases it after the commit.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_REJECT = 3'd4
    } nvg_state_t;

    localparam int NVG_AW = 15;
    localparam int NVG_DW = 8;

endpackage

// File: rtl/nvg_sync.sv
module nvg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/nvg_mem.sv
module nvg_mem #(
    parameter int AW    = 15,
    parameter int DW    = 8,
    parameter int DEPTH = 2048
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int UW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit FULL = (DEPTH == (1 << UW));

    logic [DW-1:0] cells [DEPTH];
    logic [UW-1:0] eff;
    logic          in_range;

    assign eff = addr[UW-1:0];

    generate
        if (UW < AW) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[AW-1:UW];
        end
        if (FULL) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = ({1'b0, eff} < (UW+1)'(DEPTH));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en && in_range) cells[eff] <= wdata;
    end

    assign rdata = in_range ? cells[eff] : '0;

endmodule

// File: rtl/nvg_ctrl.sv
module nvg_ctrl
    import nvg_pkg::*;
#(
    parameter int REC_CYC = 4,
    parameter bit ERR_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic we_s,
    input  logic oe_s,
    input  logic sup_s,
    input  logic wp_s,
    output logic drive_en,
    output logic commit,
    output logic err_pulse
);

    localparam int RW = $clog2(REC_CYC + 1) < 1 ? 1 : $clog2(REC_CYC + 1);

    nvg_state_t state, nxt;
    logic [RW-1:0] rec_cnt;
    logic          prev_act;
    logic          active, start, rec_ok, deny;

    assign active = !ce_s && !we_s;
    assign start  = active && !prev_act;
    assign rec_ok = (rec_cnt >= RW'(REC_CYC));
    assign deny   = wp_s || !rec_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_act <= 1'b0;
            rec_cnt  <= RW'(REC_CYC);
        end else begin
            prev_act <= active;
            if (!we_s)       rec_cnt <= '0;
            else if (!rec_ok) rec_cnt <= rec_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!sup_s) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    if (!active) nxt = ST_IDLE;
                ST_IDLE: begin
                    if (start)      nxt = deny ? ST_REJECT : ST_WRITE;
                    else if (!ce_s) nxt = ST_READ;
                end
                ST_READ: begin
                    if (ce_s)       nxt = ST_IDLE;
                    else if (start) nxt = deny ? ST_REJECT : ST_WRITE;
                end
                ST_WRITE:  if (!active) nxt = ST_IDLE;
                ST_REJECT: if (!active) nxt = ST_IDLE;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        drive_en  = (state == ST_READ) && sup_s && !ce_s && we_s && !oe_s;
        commit    = (state == ST_WRITE) && sup_s && !wp_s && !active;
        err_pulse = ERR_EN && start && (wp_s || !sup_s);
    end

endmodule

// File: rtl/nvram_gate.sv
module nvram_gate #(
    parameter int DENSITY_KB  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int REC_CYC     = 4,
    parameter bit ERR_EN      = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [14:0] addr,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_out,
    output logic        data_oe,
    input  logic        supply_ok,
    input  logic        wp_sw,
    output logic        err_flag
);

    import nvg_pkg::*;

    localparam int DEPTH = DENSITY_KB * 1024;
    localparam int BUSW  = NVG_AW + NVG_DW;

    logic ce_s, we_s, oe_s, sup_s, wp_s;
    logic drive_en, commit, err_pulse;
    logic [NVG_AW-1:0] addr_s;
    logic [NVG_DW-1:0] din_s, rdata;

    nvg_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_ctl_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({ce_n, we_n, oe_n, supply_ok, wp_sw}),
        .q   ({ce_s, we_s, oe_s, sup_s, wp_s})
    );

    nvg_sync #(.W(BUSW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({addr, data_in}),
        .q   ({addr_s, din_s})
    );

    nvg_ctrl #(.REC_CYC(REC_CYC), .ERR_EN(ERR_EN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .we_s      (we_s),
        .oe_s      (oe_s),
        .sup_s     (sup_s),
        .wp_s      (wp_s),
        .drive_en  (drive_en),
        .commit    (commit),
        .err_pulse (err_pulse)
    );

    nvg_mem #(.AW(NVG_AW), .DW(NVG_DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .wr_en (commit),
        .addr  (addr_s),
        .wdata (din_s),
        .rdata (rdata)
    );

    assign data_oe  = drive_en;
    assign data_out = drive_en ? rdata : '0;
    assign err_flag = err_pulse;

endmodule

// File: rtl/nvg_gate_checker.sv
module nvg_gate_checker (
    input logic clk,
    input logic rst_n,
    input logic ce_s,
    input logic we_s,
    input logic oe_s,
    input logic sup_s,
    input logic wp_s,
    input logic commit,
    input logic data_oe,
    input logic err_flag
);

    assert_drive_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!ce_s && we_s && !oe_s));

    assert_commit_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((ce_s || we_s) && $past(!ce_s && !we_s)));

    assert_we_cuts_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |-> !data_oe);

    assert_supply_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |-> (!data_oe && !commit));

    assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !wp_s);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !err_flag);

endmodule

bind nvram_gate nvg_gate_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .we_s     (we_s),
    .oe_s     (oe_s),
    .sup_s    (sup_s),
    .wp_s     (wp_s),
    .commit   (commit),
    .data_oe  (data_oe),
    .err_flag (err_flag)
);

// File: tb/nvram_gate_test.sv
module nvram_gate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        supply_ok = 1'b1;
    logic        wp_sw = 1'b0;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_gate uut (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .data_in (data_in), .data_out (data_out), .data_oe (data_oe),
        .supply_ok (supply_ok), .wp_sw (wp_sw), .err_flag (err_flag)
    );

    always @(posedge clk) if (rst_n && err_flag) err_seen++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        addr = a; data_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        step(4);
        we_n = 1'b1;
        step(2);
        ce_n = 1'b1;
        step(6);
    endtask

    task automatic do_read(input logic [14:0] a, output logic [7:0] d, output logic oe);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        step(5);
        d = data_out; oe = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        step(3);
    endtask

    task automatic t_reset();
        check("R11 data_oe after reset", data_oe, 0);
        check("R11 err_flag after reset", err_flag, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic o;
        do_write(15'h0010, 8'hA5);
        do_write(15'h0011, 8'h3C);
        do_read(15'h0010, d, o);
        check("R1 read drive", o, 1);
        check("R2 read A5", d, 8'hA5);
        do_read(15'h0011, d, o);
        check("R2 read 3C", d, 8'h3C);
        addr = 15'h0010; ce_n = 1'b0; oe_n = 1'b1; step(5);
        check("R1 oe high no drive", data_oe, 0);
        check("R1 oe high data zero", data_out, 0);
        ce_n = 1'b1; step(3);
    endtask

    task automatic t_ce_end();
        logic [7:0] d; logic o;
        addr = 15'h0020; data_in = 8'h77; ce_n = 1'b0; we_n = 1'b0;
        step(4);
        ce_n = 1'b1;
        step(3);
        data_in = 8'h00; we_n = 1'b1;
        step(6);
        do_read(15'h0020, d, o);
        check("R3 ce-ended write", d, 8'h77);
    endtask

    task automatic t_we_cut();
        logic [7:0] d; logic o;
        addr = 15'h0010; data_in = 8'h5A; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        step(5);
        check("R4 driving before WE", data_oe, 1);
        we_n = 1'b0;
        step(3);
        check("R4 WE fall cuts drive", data_oe, 0);
        we_n = 1'b1; oe_n = 1'b1;
        step(2);
        ce_n = 1'b1;
        step(6);
        do_read(15'h0010, d, o);
        check("R4 write after read", d, 8'h5A);
    endtask

    task automatic t_we_first();
        int drove = 0;
        addr = 15'h0030; data_in = 8'h81; we_n = 1'b0;
        step(3);
        ce_n = 1'b0; oe_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (data_oe) drove++;
        end
        check("R5 no drive when WE first", drove, 0);
        we_n = 1'b1; oe_n = 1'b1; step(2); ce_n = 1'b1; step(6);
    endtask

    task automatic t_supply();
        logic [7:0] d; logic o; int e0;
        e0 = err_seen;
        supply_ok = 1'b0; step(4);
        do_write(15'h0011, 8'hEE);
        do_read(15'h0011, d, o);
        check("R6 no drive supply low", o, 0);
        check("R10 err on supply-low write", err_seen - e0, 1);
        supply_ok = 1'b1; step(4);
        do_read(15'h0011, d, o);
        check("R6 write ignored supply low", d, 8'h3C);
    endtask

    task automatic t_protect();
        logic [7:0] d; logic o; int e0;
        e0 = err_seen;
        wp_sw = 1'b1; step(4);
        do_write(15'h0010, 8'h11);
        do_read(15'h0010, d, o);
        check("R7 read works protected", o, 1);
        check("R7 write suppressed", d, 8'h5A);
        check("R10 err on protected write", err_seen - e0, 1);
        wp_sw = 1'b0; step(4);
        e0 = err_seen;
        do_write(15'h0010, 8'h22);
        check("R10 no err on good write", err_seen - e0, 0);
    endtask

    task automatic t_alias();
        logic [7:0] d; logic o;
        do_write(15'h0805, 8'hC3);
        do_read(15'h0005, d, o);
        check("R8 upper bits ignored", d, 8'hC3);
        do_write(15'h7805, 8'h4B);
        do_read(15'h0005, d, o);
        check("R8 alias 0x7805", d, 8'h4B);
    endtask

    task automatic t_recovery(input int hi, input logic [7:0] exp, input string tag);
        logic [7:0] d; logic o;
        addr = 15'h0040; data_in = 8'h90; ce_n = 1'b0; we_n = 1'b0;
        step(4);
        we_n = 1'b1;
        step(hi);
        data_in = 8'h91; we_n = 1'b0;
        step(4);
        we_n = 1'b1; step(2); ce_n = 1'b1; step(6);
        do_read(15'h0040, d, o);
        check(tag, d, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog R1 act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(4);
        t_reset();
        t_basic();
        t_ce_end();
        t_we_cut();
        t_we_first();
        t_supply();
        t_protect();
        t_alias();
        t_recovery(1, 8'h90, "R9 short recovery discards");
        t_recovery(6, 8'h91, "R9 long recovery accepts");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule